// File: doc/BRIEF.md
# Filter Drop and Error Logger

This block sits beside a packet filter pipeline and takes in single-cycle event pulses from it. There are five drop reasons, one bad-checksum flag and two table parity errors. Each parity error arrives with the address of the table entry that failed. The block turns these pulses into the state software needs: sticky log bits for each drop reason, two saturating counters that clear when read, three interrupt status bits with their own enables, and a captured failing address for each of the two tables.

Software reaches all of this state through a small register port. The port has eight word addresses. Reads are combinational, and writes take effect at the clock edge. The log bits and the status bits are cleared by writing ones to them. A single interrupt line is raised while any status bit is set and not masked.

Top module: `drop_err_logger`

## Requirements
- R1: Each drop reason has a sticky log bit. A pulse on `ev_drop[i]` sets bit i of the cause log at address 0 on the next edge, unless the cause mask bit i is set. Bit positions: 0 = TCP control, 1 = L2 address, 2 = class code, 3 = table lookup, 4 = VLAN.
- R2: The cause mask at address 1 is read/write, 5 bits wide, and resets to 0. A cause whose mask bit is 1 leaves its log bit unchanged.
- R3: Writing to address 0 clears every cause log bit that is 1 in the write data. When a clear and an event for the same bit land in the same cycle, the bit stays set.
- R4: The drop counter at address 4 adds one in each cycle in which any drop bit is pulsed, whatever the mask says. It stops at all ones. Reading address 4 returns the count and clears the counter; if a drop arrives in the same cycle as that read, the counter becomes 1.
- R5: The bad-checksum counter at address 5 adds one per `ev_bad_csum` pulse. It saturates and clears on read in the same way as the drop counter.
- R6: The interrupt status at address 2 has three sticky bits: bit 0 = any drop, bit 1 = lookup-table parity error, bit 2 = VLAN-table parity error. Writing ones to address 2 clears the matching bits. An event in the same cycle as its clear wins.
- R7: The interrupt mask at address 3 is 3 bits wide, uses the same bit positions, and resets to all ones. `irq` is high exactly while some status bit is 1 and its mask bit is 0.
- R8: When a parity event arrives and that table's status bit is clear, the entry address is captured into the table's log. The lookup-table log is at address 6 and the VLAN-table log is at address 7. Later errors leave the log unchanged until that status bit is cleared.
- R9: After reset, every register reads 0 except the interrupt mask, which reads 7, and `irq` is low.
- R10: A parity event in the same cycle as the clear of its status bit leaves the status set and captures the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_drop | input | N_CAUSE | Drop reason pulses |
| ev_bad_csum | input | 1 | Bad checksum pulse |
| ev_lkp_par | input | 1 | Lookup-table parity error pulse |
| lkp_par_addr | input | LKP_AW | Failing lookup-table entry |
| ev_vlan_par | input | 1 | VLAN-table parity error pulse |
| vlan_par_addr | input | VLAN_AW | Failing VLAN-table entry |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears counters) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, combinational on reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the cycles in which an event and a clear collide.

- Cause log and status bits: a design where the clear wins would drop the new event.
- Counter clear on read: a design that lost the event here would read zero afterwards instead of one.
- Saturation: the bad-checksum counter is driven past all ones, where a wrapping counter would return to small values.
- Parity logs: repeated parity errors must leave the first address in place. A log that tracked every error would show the last address instead.
- Masks: masked causes and masked interrupt sources are exercised, which exposes a mask with inverted sense.

// File: rtl/drop_err_logger.sv
module drop_err_logger #(
  parameter int N_CAUSE = 5,
  parameter int CNT_W   = 16,
  parameter int LKP_AW  = 10,
  parameter int VLAN_AW = 7,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CAUSE-1:0] ev_drop,
  input  logic               ev_bad_csum,
  input  logic               ev_lkp_par,
  input  logic [LKP_AW-1:0]  lkp_par_addr,
  input  logic               ev_vlan_par,
  input  logic [VLAN_AW-1:0] vlan_par_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [2:0]         reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic               irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [N_CAUSE-1:0] clog, cmask;
  logic [2:0]         stat, imask;
  logic [CNT_W-1:0]   dcnt, ccnt;
  logic [LKP_AW-1:0]  laddr;
  logic [VLAN_AW-1:0] vaddr;

  wire any_drop = |ev_drop;
  wire [N_CAUSE-1:0] clog_clr = (reg_wr && reg_addr == 3'd0) ? reg_wdata[N_CAUSE-1:0] : '0;
  wire [2:0] stat_clr  = (reg_wr && reg_addr == 3'd2) ? reg_wdata[2:0] : 3'b000;
  wire [2:0] stat_hold = stat & ~stat_clr;
  wire [2:0] stat_ev   = {ev_vlan_par, ev_lkp_par, any_drop};

  wire [CNT_W-1:0] dbase = (reg_rd && reg_addr == 3'd4) ? '0 : dcnt;
  wire [CNT_W-1:0] cbase = (reg_rd && reg_addr == 3'd5) ? '0 : ccnt;
  wire [CNT_W-1:0] dnext = (any_drop && dbase != CNT_MAX) ? dbase + 1'b1 : dbase;
  wire [CNT_W-1:0] cnext = (ev_bad_csum && cbase != CNT_MAX) ? cbase + 1'b1 : cbase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clog  <= '0;
      cmask <= '0;
      stat  <= '0;
      imask <= 3'b111;
      dcnt  <= '0;
      ccnt  <= '0;
      laddr <= '0;
      vaddr <= '0;
    end else begin
      clog <= (clog & ~clog_clr) | (ev_drop & ~cmask);
      if (reg_wr && reg_addr == 3'd1) cmask <= reg_wdata[N_CAUSE-1:0];
      if (reg_wr && reg_addr == 3'd3) imask <= reg_wdata[2:0];
      stat <= stat_hold | stat_ev;
      if (ev_lkp_par && !stat_hold[1]) laddr <= lkp_par_addr;
      if (ev_vlan_par && !stat_hold[2]) vaddr <= vlan_par_addr;
      dcnt <= dnext;
      ccnt <= cnext;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = DW'(clog);
      3'd1:    reg_rdata = DW'(cmask);
      3'd2:    reg_rdata = DW'(stat);
      3'd3:    reg_rdata = DW'(imask);
      3'd4:    reg_rdata = DW'(dcnt);
      3'd5:    reg_rdata = DW'(ccnt);
      3'd6:    reg_rdata = DW'(laddr);
      default: reg_rdata = DW'(vaddr);
    endcase
  end

  assign irq = |(stat & ~imask);
endmodule

module drop_err_logger_chk #(
  parameter int N_CAUSE = 5,
  parameter int CNT_W   = 16,
  parameter int LKP_AW  = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_CAUSE-1:0] ev_drop,
  input logic [N_CAUSE-1:0] cmask,
  input logic [N_CAUSE-1:0] clog,
  input logic [2:0]         stat,
  input logic [2:0]         imask,
  input logic [CNT_W-1:0]   dcnt,
  input logic [LKP_AW-1:0]  laddr,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [2:0]         reg_addr,
  input logic               irq
);
  a_r1_log_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drop[0] && !cmask[0]) |=> clog[0]);
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (&dcnt && !(reg_rd && reg_addr == 3'd4)) |=> &dcnt);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] && !(reg_wr && reg_addr == 3'd2)) |=> stat[0]);
  a_r7_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&imask) |-> !irq);
  a_r8_first_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[1] && !(reg_wr && reg_addr == 3'd2)) |=> $stable(laddr));
endmodule

bind drop_err_logger drop_err_logger_chk #(.N_CAUSE(N_CAUSE), .CNT_W(CNT_W), .LKP_AW(LKP_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_drop(ev_drop), .cmask(cmask), .clog(clog),
  .stat(stat), .imask(imask), .dcnt(dcnt), .laddr(laddr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .irq(irq));

// File: tb/tb_drop_err_logger.sv
module tb_drop_err_logger;
  localparam int CLK_P = 10;
  localparam int NC = 5, CW = 16, LAW = 10, VAW = 7, DW = 32;
  localparam logic [CW-1:0] MAXC = {CW{1'b1}};

  logic clk = 0, rst_n = 0;
  logic [NC-1:0] ev_drop = '0;
  logic ev_bad_csum = 0, ev_lkp_par = 0, ev_vlan_par = 0;
  logic [LAW-1:0] lkp_par_addr = '0;
  logic [VAW-1:0] vlan_par_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [NC-1:0] m_clog, m_cmask;
  logic [2:0] m_stat, m_imask;
  logic [CW-1:0] m_dcnt, m_ccnt;
  logic [LAW-1:0] m_laddr;
  logic [VAW-1:0] m_vaddr;

  drop_err_logger #(.N_CAUSE(NC), .CNT_W(CW), .LKP_AW(LAW), .VLAN_AW(VAW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ev_drop(ev_drop), .ev_bad_csum(ev_bad_csum),
    .ev_lkp_par(ev_lkp_par), .lkp_par_addr(lkp_par_addr), .ev_vlan_par(ev_vlan_par),
    .vlan_par_addr(vlan_par_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [DW-1:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return DW'(m_clog);
      3'd1: return DW'(m_cmask);
      3'd2: return DW'(m_stat);
      3'd3: return DW'(m_imask);
      3'd4: return DW'(m_dcnt);
      3'd5: return DW'(m_ccnt);
      3'd6: return DW'(m_laddr);
      default: return DW'(m_vaddr);
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R4";
      3'd5: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_clog = '0; m_cmask = '0; m_stat = '0; m_imask = 3'b111;
    m_dcnt = '0; m_ccnt = '0; m_laddr = '0; m_vaddr = '0;
  endtask

  task automatic cyc(input logic [NC-1:0] d, input logic c, input logic lp, input logic [LAW-1:0] la,
                     input logic vp, input logic [VAW-1:0] va, input logic w, input logic r,
                     input logic [2:0] a, input logic [DW-1:0] wd, input string req);
    logic [NC-1:0] cclr;
    logic [2:0] sclr, hold;
    logic [CW-1:0] b;
    @(negedge clk);
    ev_drop = d; ev_bad_csum = c; ev_lkp_par = lp; lkp_par_addr = la;
    ev_vlan_par = vp; vlan_par_addr = va; reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = wd;
    #1;
    if (r) check(reg_rdata, exp_read(a), req);
    @(posedge clk);
    cclr = (w && a == 3'd0) ? wd[NC-1:0] : '0;
    m_clog = (m_clog & ~cclr) | (d & ~m_cmask);
    if (w && a == 3'd1) m_cmask = wd[NC-1:0];
    if (w && a == 3'd3) m_imask = wd[2:0];
    sclr = (w && a == 3'd2) ? wd[2:0] : 3'b000;
    hold = m_stat & ~sclr;
    if (lp && !hold[1]) m_laddr = la;
    if (vp && !hold[2]) m_vaddr = va;
    m_stat = hold | {vp, lp, |d};
    b = (r && a == 3'd4) ? '0 : m_dcnt;
    m_dcnt = (|d && b != MAXC) ? b + 1'b1 : b;
    b = (r && a == 3'd5) ? '0 : m_ccnt;
    m_ccnt = (c && b != MAXC) ? b + 1'b1 : b;
    #1;
    check(DW'(irq), DW'(|(m_stat & ~m_imask)), "R7");
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    cyc('0, 0, 0, '0, 0, '0, 0, 1, a, '0, req);
  endtask
  task automatic wr(input logic [2:0] a, input logic [DW-1:0] wd);
    cyc('0, 0, 0, '0, 0, '0, 1, 0, a, wd, "R3");
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check(DW'(irq), 0, "R9");
    for (int a = 0; a < 8; a++) rd(3'(a), "R9");
    // R1 / R2: mask cause 2, pulse 2 and 4
    wr(3'd1, 32'h04);
    cyc(5'b10100, 0, 0, '0, 0, '0, 0, 0, 3'd0, '0, "R1");
    rd(3'd0, "R2");
    // R3: clear bit 4 while bit 4 pulses again; clear bit 0 after it was set
    cyc(5'b00001, 0, 0, '0, 0, '0, 0, 0, 3'd0, '0, "R1");
    cyc(5'b10000, 0, 0, '0, 0, '0, 1, 0, 3'd0, 32'h11, "R3");
    rd(3'd0, "R3");
    // R4: read with drop in same cycle
    cyc(5'b00010, 0, 0, '0, 0, '0, 0, 1, 3'd4, '0, "R4");
    rd(3'd4, "R4");
    // R7: unmask all, status enables irq
    wr(3'd3, 32'h0);
    rd(3'd2, "R6");
    // R8: first parity address held
    cyc('0, 0, 1, 10'h155, 1, 7'h21, 0, 0, 3'd0, '0, "R8");
    cyc('0, 0, 1, 10'h0aa, 1, 7'h12, 0, 0, 3'd0, '0, "R8");
    rd(3'd6, "R8");
    rd(3'd7, "R8");
    // R10: clear with simultaneous event captures new address
    cyc('0, 0, 1, 10'h3c3, 0, '0, 1, 0, 3'd2, 32'h6, "R10");
    rd(3'd6, "R10");
    rd(3'd2, "R10");
    rd(3'd7, "R10");
    wr(3'd2, 32'h7);
    rd(3'd2, "R6");
    // R5: saturation
    for (int i = 0; i < 65540; i++) cyc('0, 1, 0, '0, 0, '0, 0, 0, 3'd0, '0, "R5");
    rd(3'd5, "R5");
    rd(3'd5, "R5");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] a;
      logic w, r;
      a = 3'($urandom_range(0, 7));
      w = ($urandom_range(0, 9) == 0);
      r = !w && ($urandom_range(0, 2) == 0);
      cyc(($urandom_range(0, 3) == 0) ? NC'($urandom) : '0, ($urandom_range(0, 3) == 0),
          ($urandom_range(0, 7) == 0), LAW'($urandom), ($urandom_range(0, 7) == 0), VAW'($urandom),
          w, r, a, $urandom, tag_of(a));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule